// File: doc/BRIEF.md
# Timer Channel Control and Value Registers

This block is the register slice of a single timer channel. It holds an 8-bit status/control register and a 16-bit channel value register behind a plain synchronous bus: word address, write strobe, write data and combinational read data. From the timer core it receives a one-cycle channel event pulse and the current counter value. It drives an interrupt request and two copies of the channel configuration: the mode-select and edge/level-select bits. One copy is in the bus clock domain. The other is in the counter clock domain.

The channel flag is set by events and cleared by writing a one to it. A hidden second-event bit stops a late clearing write from discarding an event that arrived after the flag was already set. Configuration changes reach the counter domain through a toggle request/acknowledge handshake, which is controlled by a three-state machine. In `S_IDLE` no transfer is in flight. In `S_LIVE` the bus-side bits were updated at once because the channel was enabled, and the machine is waiting for the acknowledge. In `S_DEFER` the channel was disabled, so the bus-side bits keep their old value until the acknowledge arrives. The transitions are:
- `S_IDLE` to `S_LIVE` on a configuration-changing write while the configuration is nonzero.
- `S_IDLE` to `S_DEFER` on a configuration-changing write while the configuration is zero.
- `S_LIVE` or `S_DEFER` back to `S_IDLE` when the synchronised acknowledge toggles.

Top module: `tmr_chan_regs`

## Requirements
- R1: Address 0 selects the control register and address 1 the value register. Any other address reads as zero. The control register reads bit 7 = flag, bit 6 = interrupt enable, bits 5:4 = mode select, bits 3:2 = edge/level select, and zero in every other bit; writes to those other bits have no effect. The value register reads in bits 15:0, with zero above, and takes only bits 15:0 of a write.
- R2: An event pulse sets the flag at the next clock edge.
- R3: A control write with bit 7 = 1 clears the flag when no second event is pending. A write with bit 7 = 0 leaves the flag unchanged.
- R4: If an event arrives while the flag is already set, the next clearing write leaves the flag set and a following clearing write clears it. An event in the same cycle as a clearing write also leaves the flag set.
- R5: The interrupt request is high exactly when the flag and the interrupt enable are both 1.
- R6: While the configuration (bits 5:2) is all zero, a written configuration is not visible on readback until the counter-domain acknowledge returns; after that it reads back as written.
- R7: While the configuration is nonzero, a written configuration reads back at the next edge. In every case, the counter-domain configuration outputs take the written value after the handshake.
- R8: While a handshake is in flight, the configuration field of a control write is dropped, and its flag and enable bits still act.
- R9: Capture mode is mode select = 00 with a nonzero edge/level select. In capture mode, bus writes to the value register are ignored, and an event loads the counter value into it in the same edge that sets the flag.
- R10: Outside capture mode, a bus write loads the value register, and events leave it unchanged.
- R11: After reset, every register bit, both configuration copies and the interrupt request are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain active-low reset |
| cnt_clk | input | 1 | Counter-domain clock |
| cnt_rst_n | input | 1 | Counter-domain active-low reset |
| addr | input | 2 | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| evt | input | 1 | Channel event pulse from the timer core |
| cnt_val | input | 16 | Counter value from the timer core |
| irq | output | 1 | Channel interrupt request |
| mode_sel | output | 2 | Bus-domain mode-select bits |
| edge_sel | output | 2 | Bus-domain edge/level-select bits |
| cnt_mode_sel | output | 2 | Counter-domain mode-select bits |
| cnt_edge_sel | output | 2 | Counter-domain edge/level-select bits |

## Verification
A channel event and a flag-clearing write can land on the same edge. So can a capture event and a bus write to the value register. The bench drives both pairs together in one cycle. It expects the flag still set after the first pair. After the second pair it expects the captured counter value, not the written data. A separate case places the clearing write after a second event has been recorded, and checks that two clears are needed.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LIVE  = 2'd1,
        S_DEFER = 2'd2
    } hs_state_e;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CFG_LO   = 2;
    localparam int CFG_W    = 4;

    // cfg[3:2] = mode select, cfg[1:0] = edge/level select
    function automatic logic is_capture(input logic [CFG_W-1:0] cfg);
        return (cfg[3:2] == 2'b00) && (cfg[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[gi] <= 1'b0;
                end else if (gi == 0) begin
                    chain[gi] <= d;
                end else begin
                    chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic wr_ctrl,
    input  logic w_flag,
    input  logic w_ie,
    output logic flag_q,
    output logic ie_q,
    output logic irq
);
    logic again_q;
    logic wr_clr;

    assign wr_clr = wr_ctrl && w_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            again_q <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            flag_q  <= evt | (flag_q & ~(wr_clr & ~again_q));
            again_q <= wr_clr ? 1'b0 : (again_q | (evt & flag_q));
            if (wr_ctrl) begin
                ie_q <= w_ie;
            end
        end
    end

    assign irq = flag_q & ie_q;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    p_w0_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && !evt) |=> $stable(flag_q));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !again_q && !evt) |=> !flag_q);
    p_no_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && (again_q || evt)) |=> flag_q);
endmodule

// File: rtl/tmr_cfg_sync.sv
module tmr_cfg_sync
    import tmr_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk,
    input  logic             cnt_rst_n,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wcfg,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CFG_W-1:0] cnt_cfg_q
);
    hs_state_e        state_q, state_d;
    logic [CFG_W-1:0] pend_q;
    logic             req_tgl_q;
    logic             ack_tgl_q;
    logic             ack_b, ack_seen_q, ack_evt;
    logic             req_c, req_seen_q, req_evt;
    logic             launch, enabled;

    assign enabled = |cfg_q;
    assign launch  = (state_q == S_IDLE) && wr_cfg && (wcfg != cfg_q);
    assign ack_evt = ack_b ^ ack_seen_q;
    assign req_evt = req_c ^ req_seen_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch) state_d = enabled ? S_LIVE : S_DEFER;
            S_LIVE:  if (ack_evt) state_d = S_IDLE;
            S_DEFER: if (ack_evt) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // bus-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            pend_q     <= '0;
            req_tgl_q  <= 1'b0;
            ack_seen_q <= 1'b0;
        end else begin
            ack_seen_q <= ack_b;
            if (launch) begin
                pend_q    <= wcfg;
                req_tgl_q <= ~req_tgl_q;
                if (enabled) cfg_q <= wcfg;
            end else if (state_q == S_DEFER && ack_evt) begin
                cfg_q <= pend_q;
            end
        end
    end

    tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(cnt_clk), .rst_n(cnt_rst_n), .d(req_tgl_q), .q(req_c));

    // counter-domain side
    always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
        if (!cnt_rst_n) begin
            req_seen_q <= 1'b0;
            ack_tgl_q  <= 1'b0;
            cnt_cfg_q  <= '0;
        end else begin
            req_seen_q <= req_c;
            if (req_evt) begin
                cnt_cfg_q <= pend_q;
                ack_tgl_q <= ~ack_tgl_q;
            end
        end
    end

    tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl_q), .q(ack_b));

    p_defer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEFER && !ack_evt) |=> $stable(cfg_q));
    p_live_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && enabled) |=> (cfg_q == $past(wcfg)));
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(pend_q));
    p_legal_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q));
endmodule

// File: rtl/tmr_val_reg.sv
module tmr_val_reg #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic [VAL_W-1:0] wval,
    input  logic             evt,
    input  logic             capture,
    input  logic [VAL_W-1:0] cnt_val,
    output logic [VAL_W-1:0] val_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (capture) begin
            if (evt) val_q <= cnt_val;
        end else if (wr_val) begin
            val_q <= wval;
        end
    end

    p_cap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && evt) |=> (val_q == $past(cnt_val)));
    p_cap_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !evt) |=> $stable(val_q));
    p_out_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && wr_val) |=> (val_q == $past(wval)));
    p_out_no_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !wr_val) |=> $stable(val_q));
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_chan_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 32,
    parameter int VAL_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt,
    input  logic [VAL_W-1:0]  cnt_val,
    output logic              irq,
    output logic [1:0]        mode_sel,
    output logic [1:0]        edge_sel,
    output logic [1:0]        cnt_mode_sel,
    output logic [1:0]        cnt_edge_sel
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_VAL  = ADDR_W'(1);

    logic             wr_ctrl, wr_val;
    logic             flag_q, ie_q;
    logic [CFG_W-1:0] cfg_q, cnt_cfg_q;
    logic [VAL_W-1:0] val_q;
    logic [7:0]       ctrl_rd;
    logic             unused_wbits;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_val  = wr_en && (addr == ADDR_VAL);
    assign unused_wbits = ^wdata;

    tmr_flag_unit u_flag (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_ctrl(wr_ctrl),
        .w_flag(wdata[FLAG_BIT]), .w_ie(wdata[IE_BIT]),
        .flag_q(flag_q), .ie_q(ie_q), .irq(irq));

    tmr_cfg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
        .wr_cfg(wr_ctrl), .wcfg(wdata[CFG_LO +: CFG_W]),
        .cfg_q(cfg_q), .cnt_cfg_q(cnt_cfg_q));

    tmr_val_reg #(.VAL_W(VAL_W)) u_val (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wval(wdata[VAL_W-1:0]),
        .evt(evt), .capture(is_capture(cfg_q)), .cnt_val(cnt_val),
        .val_q(val_q));

    assign ctrl_rd      = {flag_q, ie_q, cfg_q, 2'b00};
    assign mode_sel     = cfg_q[3:2];
    assign edge_sel     = cfg_q[1:0];
    assign cnt_mode_sel = cnt_cfg_q[3:2];
    assign cnt_edge_sel = cnt_cfg_q[1:0];

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[7:0] = ctrl_rd;
        end else if (addr == ADDR_VAL) begin
            rdata[VAL_W-1:0] = val_q;
        end
    end

    p_irq_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctrl_rd[7] && ctrl_rd[6]));
    p_reset_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_rd == 8'h00 && val_q == '0 && !irq));
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CTRL) |-> (rdata[1:0] == 2'b00 && rdata[DATA_W-1:8] == '0));
endmodule

// File: tb/sim_tmr_chan_regs.sv
module sim_tmr_chan_regs;
    logic        clk = 1'b0, cnt_clk = 1'b0;
    logic        rst_n = 1'b0, cnt_rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        irq;
    logic [1:0]  mode_sel, edge_sel, cnt_mode_sel, cnt_edge_sel;

    always #5 clk = ~clk;
    always #6.5 cnt_clk = ~cnt_clk;

    tmr_chan_regs u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .evt(evt), .cnt_val(cnt_val), .irq(irq),
        .mode_sel(mode_sel), .edge_sel(edge_sel),
        .cnt_mode_sel(cnt_mode_sel), .cnt_edge_sel(cnt_edge_sel));

    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic        exp_irq;
        int          req;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (it.kind == 0) begin
                    if (rdata !== it.exp || irq !== it.exp_irq) begin
                        n_bad++;
                        $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                                 it.req, rdata, irq, it.exp, it.exp_irq);
                    end
                end else begin
                    if ({cnt_mode_sel, cnt_edge_sel} !== it.exp[3:0]) begin
                        n_bad++;
                        $display("FAIL R%0d: counter cfg=%b expected %b",
                                 it.req, {cnt_mode_sel, cnt_edge_sel}, it.exp[3:0]);
                    end
                end
            end
        end
    end

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] e,
                          input logic ei, input int r);
        addr = a;
        #1;
        q.push_back('{0, e, ei, r});
        ->sample_ev;
        #1;
    endtask

    task automatic chk_cnt(input logic [3:0] e, input int r);
        #1;
        q.push_back('{1, {28'd0, e}, 1'b0, r});
        ->sample_ev;
        #1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic with_evt);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; evt = with_evt;
        @(negedge clk);
        wr_en = 1'b0; evt = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
    endtask

    task automatic wait_ctrl_cfg(input logic [3:0] e);
        for (int i = 0; i < 60; i++) begin
            addr = 2'd0;
            #1;
            if (rdata[5:2] == e) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_cnt_cfg(input logic [3:0] e);
        for (int i = 0; i < 60; i++) begin
            #1;
            if ({cnt_mode_sel, cnt_edge_sel} == e) break;
            @(negedge clk);
        end
    endtask

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cnt_rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk_rd(2'd0, 32'h0, 1'b0, 11);
        chk_rd(2'd1, 32'h0, 1'b0, 11);
        chk_cnt(4'b0000, 11);

        // R1: reserved bits ignore writes, enable set
        bus_wr(2'd0, 32'hFFFF_FF43, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 1);
        chk_rd(2'd2, 32'h0, 1'b0, 1);

        // R2 / R5: event sets flag, irq follows
        pulse_evt();
        chk_rd(2'd0, 32'hC0, 1'b1, 2);

        // R3: writing 0 to flag keeps it, writing 1 clears
        bus_wr(2'd0, 32'h40, 1'b0);
        chk_rd(2'd0, 32'hC0, 1'b1, 3);
        bus_wr(2'd0, 32'hC0, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 3);

        // R4: second event before clear needs two clears
        pulse_evt();
        pulse_evt();
        bus_wr(2'd0, 32'hC0, 1'b0);
        chk_rd(2'd0, 32'hC0, 1'b1, 4);
        bus_wr(2'd0, 32'hC0, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 4);

        // R4: event in same cycle as clear
        bus_wr(2'd0, 32'hC0, 1'b1);
        chk_rd(2'd0, 32'hC0, 1'b1, 4);
        bus_wr(2'd0, 32'hC0, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 4);

        // R5: flag without enable gives no irq
        pulse_evt();
        bus_wr(2'd0, 32'h00, 1'b0);
        chk_rd(2'd0, 32'h80, 1'b0, 5);
        bus_wr(2'd0, 32'h80, 1'b0);
        chk_rd(2'd0, 32'h00, 1'b0, 5);

        // R6: disabled channel defers; R8: in-flight cfg dropped, ie applied
        bus_wr(2'd0, 32'h04, 1'b0);
        chk_rd(2'd0, 32'h00, 1'b0, 6);
        bus_wr(2'd0, 32'h48, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 8);
        wait_ctrl_cfg(4'b0001);
        chk_rd(2'd0, 32'h44, 1'b0, 6);
        chk_cnt(4'b0001, 7);
        repeat (10) @(negedge clk);

        // R9: capture mode ignores bus write, event loads counter
        bus_wr(2'd1, 32'h1234, 1'b0);
        chk_rd(2'd1, 32'h0, 1'b0, 9);
        cnt_val = 16'hBEEF;
        bus_wr(2'd1, 32'h7777, 1'b1);
        chk_rd(2'd0, 32'hC4, 1'b1, 9);
        chk_rd(2'd1, 32'hBEEF, 1'b1, 9);
        bus_wr(2'd0, 32'hC4, 1'b0);
        chk_rd(2'd0, 32'h44, 1'b0, 3);

        // R7: enabled channel updates at once, counter copy after handshake
        bus_wr(2'd0, 32'h54, 1'b0);
        chk_rd(2'd0, 32'h54, 1'b0, 7);
        wait_cnt_cfg(4'b0101);
        chk_cnt(4'b0101, 7);
        repeat (10) @(negedge clk);

        // R10: output mode writes load, events do not
        bus_wr(2'd1, 32'h5A5A, 1'b0);
        chk_rd(2'd1, 32'h5A5A, 1'b0, 10);
        cnt_val = 16'h1111;
        pulse_evt();
        chk_rd(2'd1, 32'h5A5A, 1'b1, 10);
        bus_wr(2'd1, 32'hFFFF_0001, 1'b0);
        chk_rd(2'd1, 32'h0001, 1'b1, 1);
        bus_wr(2'd0, 32'hD4, 1'b0);
        chk_rd(2'd0, 32'h54, 1'b0, 3);

        // R7: disabling an enabled channel is immediate
        bus_wr(2'd0, 32'h40, 1'b0);
        chk_rd(2'd0, 32'h40, 1'b0, 7);
        wait_cnt_cfg(4'b0000);
        chk_cnt(4'b0000, 7);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule